// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block collects service requests for a four-channel DMA engine and decides which channel is served next. Requests come from two sources. Each channel has an external request pin, and the active level of these pins is programmable. Each channel also has a software request bit. The host sets or clears these bits one at a time with a coded byte written to the request port. The two sources are OR-ed per channel. Software bits cannot be masked, and they pass through the same arbitration as the pins.

An 8-bit control register selects fixed or rotating priority, the active level of the request pins and the active level of the acknowledge pins. It also has a bit that stops the arbiter from issuing new grants. When the arbiter is idle and at least one channel requests, it registers a one-hot grant. It holds that grant until the transfer logic pulses service-complete. That pulse clears the grant, records the channel as the one most recently served, and clears that channel's software request bit. The grant is driven to the acknowledge pins at the programmed level.

A master-clear strobe returns the block to its reset state. The host can read the software request bits back.

Top module: `dma_req_arbiter`

## Requirements
- R1: A write on the request port selects a channel with data bits 1:0 and writes data bit 2 into that channel's software request bit (1 sets it, 0 clears it). Data bits 7:3 have no effect. The new value is visible from the clock edge that takes the write.
- R2: While the read strobe is high, read data carries the software request bits of channels 3..0 in bits 3:0 and ones in bits 7:4. While the read strobe is low, read data is zero.
- R3: Reset and the master-clear strobe clear the software request bits, the control register and any grant. They also return the rotation state, so that the next rotating arbitration ranks channel 0 highest.
- R4: A channel requests when its software bit is set or its pin is at the active level. Software bits are never masked. A grant is issued only to a channel that was requesting in the cycle before the grant appeared.
- R5: With control bit 4 clear (fixed priority), the lowest-numbered requesting channel wins.
- R6: With control bit 4 set (rotating priority), the search starts at the channel after the one served last and wraps from 3 to 0. The channel just served therefore has the lowest priority.
- R7: Control bit 6 clear makes a request pin active high. Control bit 6 set makes it active low.
- R8: Control bit 7 set drives each acknowledge pin high for the granted channel and low for the others. Control bit 7 clear drives the inverse of that pattern.
- R9: While control bit 2 is set, no new grant is issued.
- R10: The grant is one-hot or zero. It appears on the clock edge after the cycle in which the arbiter is idle, enabled and sees a request. It stays unchanged until a service-complete pulse, and it is zero from the edge that takes that pulse.
- R11: A service-complete pulse while a grant is held clears the granted channel's software request bit. If the same cycle carries a request-port write to that channel, the write decides the bit's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_req | input | 1 | Write strobe for the software request port |
| host_wr_ctl | input | 1 | Write strobe for the control register |
| host_mclr | input | 1 | Master-clear strobe |
| host_rd_req | input | 1 | Read strobe for the software request bits |
| host_wdata | input | 8 | Host write data |
| chan_req_pin | input | 4 | External request pins, active level set by control bit 6 |
| svc_done | input | 1 | Pulse marking the end of service for the granted channel |
| grant | output | 4 | One-hot grant, active high |
| chan_ack_pin | output | 4 | Acknowledge pins, active level set by control bit 7 |
| host_rdata | output | 8 | Read data |

## Verification
The bench applies every combination of software and pin request patterns. Each combination runs under both priority schemes and both pin polarities, with the acknowledge polarity alternating between combinations. Every request is then served to completion, so that the rotation pointer walks through each reachable position. This exposes a pointer that fails to move past the served channel, or one that is not restored by master clear. Either fault sends a grant to the same channel again under rotating priority.

The bench writes garbage into the ignored data bits and sets up patterns by setting bits and then clearing them. A decoder that looks at too many data bits, or that treats every write as a set, then leaves a wrong readback. Two more faults are caught directly. A halt bit that only stalls for a cycle shows up as a grant during the halted setup phase. A missing software-bit clear after service shows up as the same channel being granted again.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

  // Control register bit positions (host software depends on them)
  localparam int CTL_HALT_BIT    = 2;
  localparam int CTL_ROTATE_BIT  = 4;
  localparam int CTL_REQLOW_BIT  = 6;
  localparam int CTL_ACKHIGH_BIT = 7;

  typedef struct packed {
    logic ack_high;
    logic req_low;
    logic rotate;
    logic halt;
  } ctl_fields_t;

  // Apply a programmable active level to a pin vector: result is active high
  function automatic logic [3:0] level_fix4(input logic [3:0] pins, input logic invert);
    level_fix4 = invert ? ~pins : pins;
  endfunction

endpackage

// File: rtl/dmarq_ctl_reg.sv
module dmarq_ctl_reg
  import dmarq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output ctl_fields_t   fields
);

  ctl_fields_t fields_q;
  ctl_fields_t fields_wr;

  always_comb begin
    fields_wr.halt     = wdata[CTL_HALT_BIT];
    fields_wr.rotate   = wdata[CTL_ROTATE_BIT];
    fields_wr.req_low  = wdata[CTL_REQLOW_BIT];
    fields_wr.ack_high = wdata[CTL_ACKHIGH_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fields_q <= '0;
    else if (mclr)   fields_q <= '0;
    else if (wr_en)  fields_q <= fields_wr;
  end

  assign fields = fields_q;

  // R3
  ctl_mclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (fields == '0));

  // R9
  ctl_halt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mclr) |=> (fields.halt == $past(wdata[CTL_HALT_BIT])));

endmodule

// File: rtl/dmarq_swreq.sv
module dmarq_swreq #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mclr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  input  logic           svc_clr_en,
  input  logic [CW-1:0]  svc_idx,
  input  logic           rd_en,
  output logic [NCH-1:0] sreq,
  output logic [DW-1:0]  rdata
);

  localparam int PAD = DW - NCH;

  logic [NCH-1:0] sreq_q;
  logic [NCH-1:0] sreq_nxt;
  logic [CW-1:0]  wsel;
  logic           wset;
  logic           wr_hits_svc;

  assign wsel        = wdata[CW-1:0];
  assign wset        = wdata[CW];
  assign wr_hits_svc = wr_en && (wsel == svc_idx);

  // Service clear first, host write applied on top (host wins on conflict)
  always_comb begin
    sreq_nxt = sreq_q;
    if (svc_clr_en) sreq_nxt[svc_idx] = 1'b0;
    if (wr_en)      sreq_nxt[wsel]    = wset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreq_q <= '0;
    else if (mclr) sreq_q <= '0;
    else           sreq_q <= sreq_nxt;
  end

  assign sreq  = sreq_q;
  assign rdata = rd_en ? {{PAD{1'b1}}, sreq_q} : '0;

  // R1
  swreq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mclr) |=> (sreq[$past(wsel)] == $past(wset)));

  // R3
  swreq_mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (sreq == '0));

  // R11
  swreq_svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_clr_en && !wr_hits_svc) |=> !sreq[$past(svc_idx)]);

  // R2
  swreq_read_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rdata[DW-1:NCH] == {PAD{1'b1}}));

endmodule

// File: rtl/dmarq_picker.sv
module dmarq_picker #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [CW-1:0]  last_idx,
  output logic [NCH-1:0] pick_oh,
  output logic [CW-1:0]  pick_idx,
  output logic           pick_any
);

  // First channel to examine under rotation: the one after the last served
  function automatic logic [CW-1:0] next_after(input logic [CW-1:0] last);
    if (int'(last) == NCH - 1) next_after = '0;
    else                       next_after = last + 1'b1;
  endfunction

  logic [CW-1:0] start;
  logic [NCH-1:0] req_rot;
  logic [CW-1:0]  off;
  logic           found;

  assign start = rotate ? next_after(last_idx) : '0;

  // Rotate the request vector so that 'start' sits at position 0
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      req_rot[i] = req[(i + int'(start)) % NCH];
    end
  end

  // Lowest set position in the rotated vector
  always_comb begin
    off   = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_rot[i]) begin
        off   = CW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    pick_idx = CW'((int'(off) + int'(start)) % NCH);
    pick_any = found;
    pick_oh  = '0;
    if (found) pick_oh[pick_idx] = 1'b1;
  end

endmodule

// File: rtl/dmarq_grant.sv
module dmarq_grant #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mclr,
  input  logic           halt,
  input  logic           ack_high,
  input  logic [NCH-1:0] pick_oh,
  input  logic [CW-1:0]  pick_idx,
  input  logic           pick_any,
  input  logic           svc_done,
  output logic [NCH-1:0] grant,
  output logic [CW-1:0]  grant_idx,
  output logic [CW-1:0]  last_idx,
  output logic           svc_fire,
  output logic [NCH-1:0] ack_pin
);

  logic [NCH-1:0] grant_q;
  logic [CW-1:0]  gidx_q;
  logic [CW-1:0]  last_q;
  logic           busy;
  logic           arb_fire;

  assign busy     = |grant_q;
  assign arb_fire = !busy && !halt && pick_any;
  assign svc_fire = busy && svc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      gidx_q  <= '0;
      last_q  <= CW'(NCH - 1);
    end else if (mclr) begin
      grant_q <= '0;
      gidx_q  <= '0;
      last_q  <= CW'(NCH - 1);
    end else if (svc_fire) begin
      grant_q <= '0;
      last_q  <= gidx_q;
    end else if (arb_fire) begin
      grant_q <= pick_oh;
      gidx_q  <= pick_idx;
    end
  end

  assign grant     = grant_q;
  assign grant_idx = gidx_q;
  assign last_idx  = last_q;
  assign ack_pin   = ack_high ? grant_q : ~grant_q;

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !svc_done && !mclr) |=> $stable(grant));

  // R10
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |=> (grant == '0));

  // R9
  grant_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && halt) |=> (grant == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dmarq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr_req,
  input  logic           host_wr_ctl,
  input  logic           host_mclr,
  input  logic           host_rd_req,
  input  logic [DW-1:0]  host_wdata,
  input  logic [NCH-1:0] chan_req_pin,
  input  logic           svc_done,
  output logic [NCH-1:0] grant,
  output logic [NCH-1:0] chan_ack_pin,
  output logic [DW-1:0]  host_rdata
);

  ctl_fields_t    ctl;
  logic [NCH-1:0] sreq;
  logic [NCH-1:0] hw_req;
  logic [NCH-1:0] eff_req;
  logic [NCH-1:0] pick_oh;
  logic [CW-1:0]  pick_idx;
  logic           pick_any;
  logic [CW-1:0]  grant_idx;
  logic [CW-1:0]  last_idx;
  logic           svc_fire;

  dmarq_ctl_reg #(.DW(DW)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .mclr   (host_mclr),
    .wr_en  (host_wr_ctl),
    .wdata  (host_wdata),
    .fields (ctl)
  );

  dmarq_swreq #(.NCH(NCH), .DW(DW)) u_swreq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclr       (host_mclr),
    .wr_en      (host_wr_req),
    .wdata      (host_wdata),
    .svc_clr_en (svc_fire),
    .svc_idx    (grant_idx),
    .rd_en      (host_rd_req),
    .sreq       (sreq),
    .rdata      (host_rdata)
  );

  // Pin level normalisation: one XOR stage per channel
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_pin
      assign hw_req[g] = chan_req_pin[g] ^ ctl.req_low;
    end
  endgenerate

  assign eff_req = sreq | hw_req;

  dmarq_picker #(.NCH(NCH)) u_pick (
    .req      (eff_req),
    .rotate   (ctl.rotate),
    .last_idx (last_idx),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  dmarq_grant #(.NCH(NCH)) u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (host_mclr),
    .halt      (ctl.halt),
    .ack_high  (ctl.ack_high),
    .pick_oh   (pick_oh),
    .pick_idx  (pick_idx),
    .pick_any  (pick_any),
    .svc_done  (svc_done),
    .grant     (grant),
    .grant_idx (grant_idx),
    .last_idx  (last_idx),
    .svc_fire  (svc_fire),
    .ack_pin   (chan_ack_pin)
  );

  // R4
  grant_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && !$past(|grant)) |-> (|(grant & $past(eff_req))));

  // R11
  svc_only_when_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire |-> (|grant));

endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr_req, host_wr_ctl, host_mclr, host_rd_req;
  logic [7:0] host_wdata;
  logic [3:0] chan_req_pin;
  logic       svc_done;
  logic [3:0] grant, chan_ack_pin;
  logic [7:0] host_rdata;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dma_req_arbiter dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_req  (host_wr_req),
    .host_wr_ctl  (host_wr_ctl),
    .host_mclr    (host_mclr),
    .host_rd_req  (host_rd_req),
    .host_wdata   (host_wdata),
    .chan_req_pin (chan_req_pin),
    .svc_done     (svc_done),
    .grant        (grant),
    .chan_ack_pin (chan_ack_pin),
    .host_rdata   (host_rdata)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Expected winner computed as a walk over channel numbers
  function automatic int exp_winner(input logic [3:0] req, input bit rot, input int last);
    for (int k = 0; k < 4; k++) begin
      int c;
      c = rot ? (last + 1 + k) % 4 : k;
      if (req[c]) return c;
    end
    return -1;
  endfunction

  function automatic logic [3:0] exp_ack(input logic [3:0] g, input bit high);
    return high ? g : (4'hF - g);
  endfunction

  task automatic run_case(input bit rot, input bit pol, input bit ackh,
                          input logic [3:0] sw, input logic [3:0] hw);
    logic [7:0] ctl;
    logic [3:0] msw;
    int         last;
    // master clear, pins idle for a cleared control register
    host_mclr    = 1'b1;
    chan_req_pin = 4'h0;
    tick();
    host_mclr = 1'b0;
    chk("R3 mclr readback", host_rdata, 8'hF0);
    chk("R3 mclr grant", {4'h0, grant}, 8'h00);
    chk("R3 mclr ack", {4'h0, chan_ack_pin}, 8'h0F);

    ctl = 8'h04 | (8'(rot) << 4) | (8'(pol) << 6) | (8'(ackh) << 7);
    host_wr_ctl = 1'b1;
    host_wdata  = ctl;
    tick();
    host_wr_ctl = 1'b0;

    // set every bit, then clear the unwanted ones; junk in bits 7:3
    host_wr_req = 1'b1;
    for (int c = 0; c < 4; c++) begin
      host_wdata = {5'((sw * 3 + hw + c) & 5'h1F & 5'h1E), 1'b1, 2'(c)};
      tick();
    end
    for (int c = 0; c < 4; c++) begin
      if (!sw[c]) begin
        host_wdata = {5'((sw + hw * 5 + c) | 5'h10), 1'b0, 2'(c)};
        tick();
      end
    end
    host_wr_req = 1'b0;

    chan_req_pin = pol ? ~hw : hw;
    tick();
    chk("R1 coded writes readback", host_rdata, {4'hF, sw});
    chk("R9 halted no grant", {4'h0, grant}, 8'h00);
    chk("R8 idle ack level", {4'h0, chan_ack_pin}, {4'h0, exp_ack(4'h0, ackh)});

    host_wr_ctl = 1'b1;
    host_wdata  = ctl & 8'hFB;
    tick();
    host_wr_ctl = 1'b0;
    chk("R10 no grant before arbitration edge", {4'h0, grant}, 8'h00);
    tick();

    msw  = sw;
    last = 3;
    for (int n = 0; n < 4; n++) begin
      logic [3:0] eff;
      logic [3:0] eg;
      int         w;
      eff = msw | hw;
      w   = exp_winner(eff, rot, last);
      if (w < 0) begin
        chk("R4 R7 nothing requesting", {4'h0, grant}, 8'h00);
        break;
      end
      eg = 4'(1 << w);
      chk(rot ? "R6 R4 R7 rotating winner" : "R5 R4 R7 fixed winner", {4'h0, grant}, {4'h0, eg});
      chk("R8 ack pins", {4'h0, chan_ack_pin}, {4'h0, exp_ack(eg, ackh)});
      tick();
      chk("R10 grant held", {4'h0, grant}, {4'h0, eg});
      svc_done = 1'b1;
      tick();
      svc_done = 1'b0;
      msw[w] = 1'b0;
      last   = w;
      chk("R10 grant dropped after service", {4'h0, grant}, 8'h00);
      chk("R11 serviced software bit cleared", host_rdata, {4'hF, msw});
      tick();
    end
  endtask

  initial begin
    rst_n        = 1'b0;
    host_wr_req  = 1'b0;
    host_wr_ctl  = 1'b0;
    host_mclr    = 1'b0;
    host_rd_req  = 1'b1;
    host_wdata   = 8'h00;
    chan_req_pin = 4'h0;
    svc_done     = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R3 reset readback", host_rdata, 8'hF0);
    chk("R3 reset grant", {4'h0, grant}, 8'h00);
    chk("R3 reset ack", {4'h0, chan_ack_pin}, 8'h0F);
    host_rd_req = 1'b0;
    #0;
    chk("R2 read strobe low", host_rdata, 8'h00);
    tick();
    host_rd_req = 1'b1;

    for (int rot = 0; rot < 2; rot++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int sw = 0; sw < 16; sw++) begin
          for (int hw = 0; hw < 16; hw++) begin
            run_case(rot[0], pol[0], sw[0] ^ hw[1], 4'(sw), 4'(hw));
          end
        end
      end
    end

    // R2: readback upper nibble with all software bits set
    host_mclr = 1'b1;
    chan_req_pin = 4'h0;
    tick();
    host_mclr   = 1'b0;
    host_wr_ctl = 1'b1;
    host_wdata  = 8'h04;
    tick();
    host_wr_ctl = 1'b0;
    host_wr_req = 1'b1;
    for (int c = 0; c < 4; c++) begin
      host_wdata = {5'h1F, 1'b1, 2'(c)};
      tick();
    end
    host_wr_req = 1'b0;
    chk("R2 full readback", host_rdata, 8'hFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad_cnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

endmodule